// File: doc/BRIEF.md
# Counter-Compare Watchdog Timer

This block supervises software by watching a free-running 16-bit counter rather than counting down. An 8-bit compare value is held against the counter's upper byte. When the lower byte rolls over from all ones to zero while the upper byte equals the compare value, the block requests a one-cycle system reset. Software keeps the system alive by refreshing. A refresh reloads the compare value with the current upper byte plus a programmed offset. The interval before expiry is therefore 256 times the offset, plus the distance from the current low byte to its next rollover.

The counter advances on ticks from a prescaler. The prescaler divides the system clock by 12, by 4, or not at all. An optional idle hold freezes the prescaler and the counter while the CPU idle input is high. Software reaches the block through simple single-cycle register writes. These writes can enable the watchdog, lock it on for good, set the offset, refresh it, force an immediate reset, and choose the clock and idle options. The clock and idle options can be changed only while the watchdog is off.

Top module: `cmpwd_top`

## Requirements
- R1: Reset state: the watchdog is armed, the divider is /12, the counter is zero and the offset and compare value are zero. The first pulse therefore comes on the 3072nd system clock edge after reset is released.
- R2: `rst_req` is high for exactly one clock. It rises after the clock edge at which the low byte wraps from 0xFF to 0x00 while the high byte equals the compare value and the watchdog is armed.
- R3: Any write to address 2 is a refresh, and its data is ignored. The refresh loads the compare value with (high byte + offset) mod 256, using the high byte before that edge. The counter does not stop, so the pulse follows 256·offset + 255 − L edges after the refresh edge, where L is the low byte before the refresh edge.
- R4: Control field bits [5:3] at address 0 select the divider: code 1 gives /4, code 2 gives /1, and every other code gives /12. A change of code restarts the prescaler phase, and no tick occurs on that edge.
- R5: When control bit 2 (idle hold) is set, each edge with `cpu_idle` high leaves the prescaler and the counter unchanged. The pulse is delayed by exactly that many edges. With idle hold clear, `cpu_idle` has no effect.
- R6: Control bit 0 is the enable. With enable and lock both clear, no pulse is produced.
- R7: Control bit 1 is the lock. Writing it as 1 sets it, and only reset clears it. While it is set the watchdog stays armed, even if a later write clears the enable.
- R8: While the watchdog is armed, a control write leaves the divider code and the idle hold bit unchanged. The enable and lock bits are still written.
- R9: A write to address 3 with data bit 0 set produces a pulse on that edge if the watchdog is armed. With bit 0 clear, or with the watchdog not armed, no pulse follows.
- R10: A refresh on the same edge as an expiry wins: no pulse is produced, and the new compare value applies.
- R11: A forced reset on the same edge as an expiry yields a single one-cycle pulse.
- R12: Address 1 holds the offset; the written byte is used by later refreshes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| cpu_idle | input | 1 | CPU idle indicator |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | Register select: 0 control, 1 offset, 2 refresh, 3 force |
| wr_data | input | 8 | Write data |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
Two pairs of functions can meet on one clock edge: a refresh and an expiry, and a forced reset and an expiry. The bench puts the block in the undivided clock mode, where the counter's value is known on every edge. It then places a refresh write exactly on the edge where the low byte wraps while the compare matches, and checks two things: that no pulse appears then, and that the next pulse lands where the refresh formula predicts. A second run places a force write on the same expiry edge and checks for a single pulse that is low on the following cycle.

// File: rtl/cmpwd_pkg.sv
package cmpwd_pkg;

   localparam int unsigned ADDR_W = 2;

   localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
   localparam logic [ADDR_W-1:0] A_OFFS  = 2'd1;
   localparam logic [ADDR_W-1:0] A_KICK  = 2'd2;
   localparam logic [ADDR_W-1:0] A_FORCE = 2'd3;

   localparam logic [2:0] SEL_SLOW = 3'd0;
   localparam logic [2:0] SEL_MID  = 3'd1;
   localparam logic [2:0] SEL_FULL = 3'd2;

   // control register layout, bit 0 at the bottom
   typedef struct packed {
      logic [2:0] sel;
      logic       idle_hold;
      logic       lock;
      logic       en;
   } ctrl_t;

   localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/cmpwd_presc.sv
module cmpwd_presc import cmpwd_pkg::*; #(
   parameter int unsigned DIV_SLOW = 12,
   parameter int unsigned DIV_MID  = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] sel,
   input  logic       restart,
   input  logic       hold,
   output logic       tick
);

   initial begin
      assert (DIV_MID >= 1 && DIV_MID <= DIV_SLOW)
         else $error("cmpwd_presc: DIV_MID out of range");
   end

   generate
      if (DIV_SLOW > 1) begin : g_div
         localparam int unsigned PW = $clog2(DIV_SLOW);
         localparam logic [PW-1:0] SLOW_M1 = PW'(DIV_SLOW - 1);
         localparam logic [PW-1:0] MID_M1  = PW'(DIV_MID - 1);

         logic [PW-1:0] phase_q;
         logic [PW-1:0] last_phase;

         always_comb begin
            case (sel)
               SEL_MID:  last_phase = MID_M1;
               SEL_FULL: last_phase = '0;
               default:  last_phase = SLOW_M1;
            endcase
         end

         assign tick = !hold && !restart && (phase_q == last_phase);

         always_ff @(posedge clk) begin
            if (!rst_n || restart) begin
               phase_q <= '0;
            end else if (!hold) begin
               phase_q <= tick ? '0 : phase_q + 1'b1;
            end
         end
      end else begin : g_nodiv
         logic unused_sel;
         assign unused_sel = ^{sel, restart, clk, rst_n};
         assign tick = !hold;
      end
   endgenerate

endmodule

// File: rtl/cmpwd_cnt.sv
module cmpwd_cnt #(
   parameter int unsigned CNT_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 step,
   output logic [CNT_W/2-1:0]   cnt_hi,
   output logic [CNT_W/2-1:0]   cnt_lo,
   output logic                 lo_wrap
);

   localparam int unsigned HW = CNT_W / 2;

   logic [HW-1:0] lo_q;
   logic [HW-1:0] hi_q;

   assign lo_wrap = step && (&lo_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else if (step) begin
         lo_q <= lo_q + 1'b1;
         if (lo_wrap) hi_q <= hi_q + 1'b1;
      end
   end

   assign cnt_hi = hi_q;
   assign cnt_lo = lo_q;

endmodule

// File: rtl/cmpwd_regs.sv
module cmpwd_regs import cmpwd_pkg::*; #(
   parameter int unsigned HW     = 8,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [HW-1:0]     cnt_hi,
   output ctrl_t             ctrl_q,
   output logic              armed,
   output logic              kick,
   output logic              force_hit,
   output logic              restart,
   output logic [HW-1:0]     offs_q,
   output logic [HW-1:0]     cmp_q
);

   initial begin
      assert (HW <= DATA_W && CTRL_W <= DATA_W)
         else $error("cmpwd_regs: data bus too narrow");
   end

   ctrl_t wr_ctrl;
   logic  ctrl_wr;
   logic  offs_wr;

   assign wr_ctrl   = ctrl_t'(wr_data[CTRL_W-1:0]);
   assign ctrl_wr   = wr_en && (wr_addr == A_CTRL);
   assign offs_wr   = wr_en && (wr_addr == A_OFFS);
   assign kick      = wr_en && (wr_addr == A_KICK);
   assign armed     = ctrl_q.en || ctrl_q.lock;
   assign force_hit = wr_en && (wr_addr == A_FORCE) && wr_data[0] && armed;
   assign restart   = ctrl_wr && !armed && (wr_ctrl.sel != ctrl_q.sel);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q.en        <= 1'b1;
         ctrl_q.lock      <= 1'b0;
         ctrl_q.idle_hold <= 1'b0;
         ctrl_q.sel       <= SEL_SLOW;
      end else if (ctrl_wr) begin
         ctrl_q.en   <= wr_ctrl.en;
         ctrl_q.lock <= ctrl_q.lock || wr_ctrl.lock;
         if (!armed) begin
            ctrl_q.idle_hold <= wr_ctrl.idle_hold;
            ctrl_q.sel       <= wr_ctrl.sel;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         offs_q <= '0;
         cmp_q  <= '0;
      end else begin
         if (offs_wr) offs_q <= wr_data[HW-1:0];
         if (kick)    cmp_q  <= cnt_hi + offs_q;
      end
   end

endmodule

// File: rtl/cmpwd_top.sv
module cmpwd_top import cmpwd_pkg::*; #(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned DIV_SLOW = 12,
   parameter int unsigned DIV_MID  = 4,
   parameter int unsigned DATA_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_idle,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              rst_req
);

   localparam int unsigned HW = CNT_W / 2;

   initial begin
      assert (CNT_W >= 4 && (CNT_W % 2) == 0)
         else $error("cmpwd_top: CNT_W must be even and at least 4");
   end

   ctrl_t         ctrl_q;
   logic          armed;
   logic          kick;
   logic          force_hit;
   logic          restart;
   logic          tick;
   logic          hold;
   logic          lo_wrap;
   logic          fire;
   logic          rst_req_q;
   logic [HW-1:0] cnt_hi;
   logic [HW-1:0] cnt_lo;
   logic [HW-1:0] offs_q;
   logic [HW-1:0] cmp_q;
   logic [2:0]    sel_q;
   logic          idle_q;
   logic          lock_q;

   assign sel_q  = ctrl_q.sel;
   assign idle_q = ctrl_q.idle_hold;
   assign lock_q = ctrl_q.lock;
   assign hold   = idle_q && cpu_idle;

   cmpwd_regs #(.HW(HW), .DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .cnt_hi    (cnt_hi),
      .ctrl_q    (ctrl_q),
      .armed     (armed),
      .kick      (kick),
      .force_hit (force_hit),
      .restart   (restart),
      .offs_q    (offs_q),
      .cmp_q     (cmp_q)
   );

   cmpwd_presc #(.DIV_SLOW(DIV_SLOW), .DIV_MID(DIV_MID)) u_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (sel_q),
      .restart (restart),
      .hold    (hold),
      .tick    (tick)
   );

   cmpwd_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (tick),
      .cnt_hi  (cnt_hi),
      .cnt_lo  (cnt_lo),
      .lo_wrap (lo_wrap)
   );

   // a refresh on the expiry edge takes precedence
   assign fire = armed && !kick && lo_wrap && (cnt_hi == cmp_q);

   always_ff @(posedge clk) begin
      if (!rst_n) rst_req_q <= 1'b0;
      else        rst_req_q <= fire || force_hit;
   end

   assign rst_req = rst_req_q;

endmodule

// File: rtl/cmpwd_chk.sv
module cmpwd_chk #(
   parameter int unsigned HW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cpu_idle,
   input logic          rst_req,
   input logic          armed,
   input logic          kick,
   input logic          force_hit,
   input logic          lo_wrap,
   input logic          lock_q,
   input logic          idle_q,
   input logic [2:0]    sel_q,
   input logic [HW-1:0] cnt_hi,
   input logic [HW-1:0] cnt_lo,
   input logic [HW-1:0] offs_q,
   input logic [HW-1:0] cmp_q
);

   a_r2_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> $past(force_hit || (lo_wrap && cnt_hi == cmp_q)));

   a_r3_kick_loads: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> (cmp_q == $past(HW'(cnt_hi + offs_q))));

   a_r5_idle_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_q && cpu_idle) |=> $stable({cnt_hi, cnt_lo}));

   a_r6_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> !rst_req);

   a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q);

   a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      armed |=> ($stable(sel_q) && $stable(idle_q)));

   a_r9_force_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      force_hit |=> rst_req);

   a_r10_kick_wins: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> (!rst_req || $past(force_hit)));

endmodule

bind cmpwd_top cmpwd_chk #(.HW(HW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_idle  (cpu_idle),
   .rst_req   (rst_req),
   .armed     (armed),
   .kick      (kick),
   .force_hit (force_hit),
   .lo_wrap   (lo_wrap),
   .lock_q    (lock_q),
   .idle_q    (idle_q),
   .sel_q     (sel_q),
   .cnt_hi    (cnt_hi),
   .cnt_lo    (cnt_lo),
   .offs_q    (offs_q),
   .cmp_q     (cmp_q)
);

// File: tb/tb_cmpwd_top.sv
module tb_cmpwd_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_idle = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       rst_req;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   cmpwd_top dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .cpu_idle (cpu_idle),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rst_req  (rst_req)
   );

   // edge count since reset release; at the negedge after edge n it reads n
   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] cw(input int sel, input bit idle, input bit lk, input bit en);
      logic [2:0] s = sel[2:0];
      return {2'b00, s, idle, lk, en};
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b0; cpu_idle = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // write takes effect on the next edge; returns at the negedge after it
   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_pulse(input int limit, output int at);
      while (!rst_req && cyc < limit) @(negedge clk);
      at = rst_req ? cyc : -1;
   endtask

   task automatic go_to(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   // disable, choose divider/idle option, enable again: edges 1..3
   task automatic setup(input int sel, input bit idle);
      wr(2'd0, cw(0, 0, 0, 0));
      wr(2'd0, cw(sel, idle, 0, 0));
      wr(2'd0, cw(sel, idle, 0, 1));
   endtask

   // undivided mode after setup: counter before edge n equals n-3
   function automatic int exp_fire(input int e, input int off);
      int l = (e - 3) % 256;
      return e + 256 * off + 255 - l;
   endfunction

   task automatic t_defaults();
      int at;
      do_reset();
      chk("R1 rst_req low after reset", int'(rst_req), 0);
      wait_pulse(5000, at);
      chk("R1 default timeout edge", at, 3072);
      @(negedge clk);
      chk("R2 pulse one cycle wide", int'(rst_req), 0);
   endtask

   task automatic t_clksel();
      int at;
      do_reset(); setup(1, 0); wait_pulse(3000, at);
      chk("R4 code 1 divide by 4", at, 2 + 4 * 256);
      do_reset(); setup(2, 0); wait_pulse(3000, at);
      chk("R4 code 2 undivided", at, 2 + 256);
      do_reset(); setup(5, 0); wait_pulse(5000, at);
      chk("R4 unused code 5 divide by 12", at, 2 + 12 * 256);
   endtask

   task automatic t_ignore();
      int at;
      do_reset();
      wr(2'd0, cw(2, 1, 0, 1));
      cpu_idle = 1'b1;
      wait_pulse(5000, at);
      chk("R8 config write ignored while armed; R5 idle without hold", at, 3072);
      cpu_idle = 1'b0;
   endtask

   task automatic t_idle();
      int at;
      do_reset(); setup(2, 1);
      cpu_idle = 1'b1;
      repeat (100) @(negedge clk);
      cpu_idle = 1'b0;
      wait_pulse(1000, at);
      chk("R5 idle hold delays pulse", at, 258 + 100);
   endtask

   task automatic t_refresh();
      int at, e;
      do_reset(); setup(2, 0);
      wr(2'd1, 8'd2);
      wait_pulse(1000, at);
      chk("R2 undivided expiry", at, 258);
      e = cyc + 1; wr(2'd2, 8'hA5);
      wait_pulse(e + 2000, at);
      chk("R3 R12 refresh offset 2 at low byte 0", at, exp_fire(e, 2));
      wr(2'd1, 8'd0);
      repeat (37) @(negedge clk);
      e = cyc + 1; wr(2'd2, 8'h00);
      wait_pulse(e + 1000, at);
      chk("R3 refresh offset 0 mid-byte", at, exp_fire(e, 0));
      wr(2'd1, 8'hFE);
      repeat (11) @(negedge clk);
      e = cyc + 1; wr(2'd2, 8'h00);
      wait_pulse(e + 70000, at);
      chk("R3 compare wraps modulo 256", at, exp_fire(e, 254));
   endtask

   task automatic t_keepalive();
      int seen = 0;
      do_reset(); setup(2, 0);
      wr(2'd1, 8'd1);
      wr(2'd2, 8'h00);
      for (int i = 0; i < 2000; i++) begin
         if (rst_req) seen++;
         if (i % 200 == 199) wr(2'd2, 8'h00);
         else @(negedge clk);
      end
      chk("R3 periodic refresh keeps quiet", seen, 0);
   endtask

   task automatic t_disable();
      int at;
      do_reset();
      wr(2'd0, cw(0, 0, 0, 0));
      wr(2'd3, 8'h01);
      wait_pulse(4000, at);
      chk("R6 R9 disabled: no timeout, no forced pulse", at, -1);
   endtask

   task automatic t_lock();
      int at;
      do_reset();
      wr(2'd0, cw(0, 0, 1, 0));
      wr(2'd0, cw(0, 0, 0, 0));
      wait_pulse(5000, at);
      chk("R7 lock keeps watchdog armed", at, 3072);
   endtask

   task automatic t_force();
      int at;
      do_reset(); setup(2, 0);
      wr(2'd3, 8'h01);
      chk("R9 forced pulse on write edge", int'(rst_req), 1);
      @(negedge clk);
      chk("R9 forced pulse one cycle", int'(rst_req), 0);
      wr(2'd3, 8'hFE);
      wait_pulse(200, at);
      chk("R9 bit 0 clear does nothing", at, -1);
   endtask

   task automatic t_same_cycle();
      int at;
      do_reset(); setup(2, 0);
      wr(2'd1, 8'd1);
      go_to(257);
      wr(2'd2, 8'h00);
      chk("R10 refresh on expiry edge suppresses pulse", int'(rst_req), 0);
      @(negedge clk);
      wait_pulse(1000, at);
      chk("R10 next expiry from new compare", at, 514);
      do_reset(); setup(2, 0);
      go_to(257);
      wr(2'd3, 8'h01);
      chk("R11 force plus expiry gives pulse", int'(rst_req), 1);
      @(negedge clk);
      chk("R11 force plus expiry single cycle", int'(rst_req), 0);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      t_defaults();
      t_clksel();
      t_ignore();
      t_idle();
      t_refresh();
      t_keepalive();
      t_disable();
      t_lock();
      t_force();
      t_same_cycle();
      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected completion");
         summary();
         $finish;
      end
   end

endmodule